// File: doc/BRIEF.md
# Indirect-Access Network Controller Register File

This block holds the 16-bit control and status registers of an Ethernet controller. The host reaches all of them through two ports that share one write strobe. A write to the address port picks a register number. After that, reads and writes on the data port go to the register that was picked. Register 0 is the command and status word. It starts and stops the controller, asks it to fetch its initialisation block, and demands a transmit poll. It also collects the interrupt sources and drives one interrupt line. The other registers hold the initialisation-block address, the bus-mode bits, a 64-bit multicast filter and a mode word. The DMA engines and the MAC read these registers as outputs.

A run-control state machine sits behind register 0. It has four states:
- `RUN_STOPPED` is the reset state.
- `RUN_INITING` means an initialisation fetch was ordered and is in progress.
- `RUN_READY` means the fetch is done but the controller has not been started.
- `RUN_ACTIVE` means transmitter and receiver are enabled.

Its transitions:
- STOP moves any state to `RUN_STOPPED`.
- INIT moves `RUN_STOPPED`, `RUN_READY` or `RUN_ACTIVE` to `RUN_INITING`.
- START moves `RUN_STOPPED` or `RUN_READY` to `RUN_ACTIVE`.
- The init-done strobe moves `RUN_INITING` to `RUN_READY`. It moves it to `RUN_ACTIVE` instead when a start was requested with, or during, the fetch.

Within one write, STOP beats INIT, and INIT beats START. Entering `RUN_INITING` gives a one-cycle init pulse, entering `RUN_ACTIVE` a start pulse, and every STOP write a stop pulse.

Top module: `netcsr_file`

## Requirements
- R1: A write with `host_port`=1 stores the register number. A read with `host_port`=1 returns that number. A data-port access (`host_port`=0) reads or writes the selected register, with the result visible on the cycle after the write edge.
- R2: After reset, register 0 reads 0x0004 (only the stop bit) and `irq` is 0.
- R3: Register 0 bit 2 is STOP and bit 0 is INIT. A write with both bits set leaves register 0 reading exactly 0x0004, and no init pulse is produced.
- R4: A write of bit 0 (INIT) outside `RUN_INITING` gives a one-cycle `init_pulse` and sets bit 0. The `init_done` strobe then sets IDON (bit 8). If bit 1 (START) was written with INIT, or during the fetch, `init_done` also enters `RUN_ACTIVE` with a `start_pulse`.
- R5: A write of bit 1 from `RUN_STOPPED` or `RUN_READY` gives a one-cycle `start_pulse`. Bits 1, 4 (TXON) and 5 (RXON) then read 1, and `tx_enable` and `rx_enable` are 1.
- R6: A write of bit 3 while active raises bit 3 and `tx_demand` for exactly one cycle. The same write while not active has no effect.
- R7: These bits of register 0 are cleared by writing 1 to them: IDON bit 8, TINT bit 9, RINT bit 10, MERR bit 11, MISS bit 12, CERR bit 13 and BABL bit 14. Writing 0 to them has no effect. An event that arrives in the same cycle as a clear leaves the flag set.
- R8: Bit 15 (ERR) reads as the OR of bits 11 to 14. Bit 7 (INTR) reads as the OR of ERR and bits 8 to 10.
- R9: Bit 6 (INEA) takes the written value. `irq` equals INTR AND INEA.
- R10: A STOP write gives a `stop_pulse` and clears all of these: TXON, RXON, START, INIT, INEA and every flag. `irq` goes to 0.
- R11: Registers 1 (init address bits 15:0), 2 (init address upper bits, masked to their width) and 3 (bus mode, bits 2:0) accept writes only in `RUN_STOPPED`. In any other state the write is ignored.
- R12: Registers 8 to 11 form the multicast filter, with register 8 as the least significant word. Register 15 is the mode word, and its bit 15 drives `promisc`.
- R13: The transmit, receive and error event inputs set their flags only outside `RUN_STOPPED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_port | input | 1 | 1 = address port, 0 = data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the port chosen by host_port |
| init_done | input | 1 | Init-block fetch finished strobe |
| tx_done_evt | input | 1 | Transmit interrupt event |
| rx_done_evt | input | 1 | Receive interrupt event |
| mem_err_evt | input | 1 | Memory error event |
| miss_evt | input | 1 | Missed frame event |
| coll_err_evt | input | 1 | Collision check error event |
| babble_evt | input | 1 | Babble event |
| irq | output | 1 | Interrupt request |
| init_pulse | output | 1 | Start init-block fetch |
| start_pulse | output | 1 | Start DMA engines |
| stop_pulse | output | 1 | Stop DMA engines |
| tx_demand | output | 1 | Transmit poll demand |
| tx_enable | output | 1 | Transmitter on |
| rx_enable | output | 1 | Receiver on |
| init_addr | output | INIT_ADDR_W | Init-block address |
| bus_mode | output | 3 | Byte swap, address mode, byte control |
| mcast_filter | output | FILTER_W | Multicast hash filter |
| promisc | output | 1 | Promiscuous mode |

## Verification
The bench first probes with INIT and STOP together. A design that lets INIT win shows 0x0001 or produces an init pulse instead of 0x0004. It then writes zeros to set flags, and clears a flag in the same cycle its event arrives. A design that clears on zero, or lets the clear win, loses events that the host has not yet seen. It also writes the address registers while active. A design that accepts those writes moves the DMA base under a running engine. Finally it issues INIT and START together, which must wait for init-done. A design that enables the engines at once starts them before the init block is loaded.

// File: rtl/netcsr_pkg.sv
package netcsr_pkg;

    typedef enum logic [1:0] {
        RUN_STOPPED = 2'd0,
        RUN_INITING = 2'd1,
        RUN_READY   = 2'd2,
        RUN_ACTIVE  = 2'd3
    } run_state_t;

    // Command and status word bit positions
    localparam int C0_INIT = 0;
    localparam int C0_STRT = 1;
    localparam int C0_STOP = 2;
    localparam int C0_TDMD = 3;
    localparam int C0_TXON = 4;
    localparam int C0_RXON = 5;
    localparam int C0_INEA = 6;
    localparam int C0_INTR = 7;
    localparam int C0_FLAG_LO = 8;
    localparam int C0_ERR  = 15;

    // Sticky flag vector, packed to map onto word bits 14:8
    localparam int FLAG_COUNT = 7;
    localparam int FL_IDON = 0;
    localparam int FL_TINT = 1;
    localparam int FL_RINT = 2;
    localparam int FL_MERR = 3;
    localparam int FL_MISS = 4;
    localparam int FL_CERR = 5;
    localparam int FL_BABL = 6;

    // Register numbers decoded by the bank
    localparam int REGN_CMD      = 0;
    localparam int REGN_IADR_LO  = 1;
    localparam int REGN_IADR_HI  = 2;
    localparam int REGN_BUSMODE  = 3;
    localparam int REGN_FILT0    = 8;
    localparam int REGN_MODE     = 15;

    localparam int BUSMODE_W = 3;

endpackage

// File: rtl/netcsr_ctrl.sv
module netcsr_ctrl
    import netcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       cmd_init,
    input  logic       cmd_strt,
    input  logic       cmd_stop,
    input  logic       cmd_tdmd,
    input  logic       cmd_inea,
    input  logic       init_done,
    output run_state_t state,
    output logic       init_seen,
    output logic       inea,
    output logic       tdmd,
    output logic       init_pulse,
    output logic       start_pulse,
    output logic       stop_pulse,
    output logic       idon_set
);

    run_state_t next_state;
    logic       start_armed;
    logic       arm_now;

    // A start requested together with, or during, an init fetch
    assign arm_now = cmd_wr && !cmd_stop && cmd_strt &&
                     (cmd_init || state == RUN_INITING);

    always_comb begin
        next_state = state;
        unique case (state)
            RUN_STOPPED: begin
                if (cmd_wr && !cmd_stop) begin
                    if (cmd_init)      next_state = RUN_INITING;
                    else if (cmd_strt) next_state = RUN_ACTIVE;
                end
            end
            RUN_INITING: begin
                if (cmd_wr && cmd_stop)
                    next_state = RUN_STOPPED;
                else if (init_done)
                    next_state = (start_armed || arm_now) ? RUN_ACTIVE : RUN_READY;
            end
            RUN_READY: begin
                if (cmd_wr) begin
                    if (cmd_stop)      next_state = RUN_STOPPED;
                    else if (cmd_init) next_state = RUN_INITING;
                    else if (cmd_strt) next_state = RUN_ACTIVE;
                end
            end
            RUN_ACTIVE: begin
                if (cmd_wr) begin
                    if (cmd_stop)      next_state = RUN_STOPPED;
                    else if (cmd_init) next_state = RUN_INITING;
                end
            end
            default: next_state = RUN_STOPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RUN_STOPPED;
        else        state <= next_state;
    end

    assign idon_set = (state == RUN_INITING) && init_done && !(cmd_wr && cmd_stop);

    // Outputs derived from the transition taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_pulse  <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            tdmd        <= 1'b0;
            inea        <= 1'b0;
            init_seen   <= 1'b0;
            start_armed <= 1'b0;
        end else begin
            init_pulse  <= (next_state == RUN_INITING) && (state != RUN_INITING);
            start_pulse <= (next_state == RUN_ACTIVE)  && (state != RUN_ACTIVE);
            stop_pulse  <= cmd_wr && cmd_stop;
            tdmd        <= cmd_wr && cmd_tdmd &&
                           (state == RUN_ACTIVE) && (next_state == RUN_ACTIVE);
            if (cmd_wr)
                inea <= cmd_stop ? 1'b0 : cmd_inea;
            if (next_state == RUN_STOPPED)
                init_seen <= 1'b0;
            else if (next_state == RUN_INITING)
                init_seen <= 1'b1;
            if (next_state != RUN_INITING)
                start_armed <= 1'b0;
            else if (arm_now)
                start_armed <= 1'b1;
        end
    end

endmodule

// File: rtl/netcsr_flags.sv
module netcsr_flags #(
    parameter int N_FLAGS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [N_FLAGS-1:0] set_evt,
    input  logic [N_FLAGS-1:0] clr_mask,
    output logic [N_FLAGS-1:0] flags
);

    // One sticky cell per source: flush beats set, set beats clear
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n || flush)  flags[i] <= 1'b0;
            else if (set_evt[i])  flags[i] <= 1'b1;
            else if (clr_mask[i]) flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/netcsr_bank.sv
module netcsr_bank
    import netcsr_pkg::*;
#(
    parameter int REG_SEL_W   = 4,
    parameter int INIT_ADDR_W = 24,
    parameter int FILTER_W    = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [REG_SEL_W-1:0]   sel,
    input  logic [15:0]            wdata,
    input  logic                   stopped,
    output logic [INIT_ADDR_W-1:0] init_addr,
    output logic [BUSMODE_W-1:0]   bus_mode,
    output logic [FILTER_W-1:0]    filter,
    output logic [15:0]            mode_word,
    output logic [15:0]            rd_data
);

    localparam int HI_W     = INIT_ADDR_W - 16;
    localparam int FILT_REG = FILTER_W / 16;

    logic [15:0]          iadr_lo;
    logic [HI_W-1:0]      iadr_hi;
    logic [FILT_REG-1:0]  filt_hit;

    assign init_addr = {iadr_hi, iadr_lo};

    // Address and bus-mode words are locked unless stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iadr_lo  <= '0;
            iadr_hi  <= '0;
            bus_mode <= '0;
            mode_word <= '0;
        end else if (wr) begin
            if (stopped && sel == REG_SEL_W'(REGN_IADR_LO)) iadr_lo  <= wdata;
            if (stopped && sel == REG_SEL_W'(REGN_IADR_HI)) iadr_hi  <= wdata[HI_W-1:0];
            if (stopped && sel == REG_SEL_W'(REGN_BUSMODE)) bus_mode <= wdata[BUSMODE_W-1:0];
            if (sel == REG_SEL_W'(REGN_MODE))               mode_word <= wdata;
        end
    end

    for (genvar k = 0; k < FILT_REG; k++) begin : g_filt
        assign filt_hit[k] = (sel == REG_SEL_W'(REGN_FILT0 + k));
        always_ff @(posedge clk) begin
            if (!rst_n)                filter[16*k +: 16] <= '0;
            else if (wr && filt_hit[k]) filter[16*k +: 16] <= wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (sel == REG_SEL_W'(REGN_IADR_LO)) rd_data = iadr_lo;
        if (sel == REG_SEL_W'(REGN_IADR_HI)) rd_data = 16'(iadr_hi);
        if (sel == REG_SEL_W'(REGN_BUSMODE)) rd_data = 16'(bus_mode);
        if (sel == REG_SEL_W'(REGN_MODE))    rd_data = mode_word;
        for (int k = 0; k < FILT_REG; k++)
            if (filt_hit[k]) rd_data = filter[16*k +: 16];
    end

endmodule

// File: rtl/netcsr_file.sv
module netcsr_file
    import netcsr_pkg::*;
#(
    parameter int REG_SEL_W   = 4,
    parameter int INIT_ADDR_W = 24,
    parameter int FILTER_W    = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_port,
    input  logic [15:0]            host_wdata,
    output logic [15:0]            host_rdata,
    input  logic                   init_done,
    input  logic                   tx_done_evt,
    input  logic                   rx_done_evt,
    input  logic                   mem_err_evt,
    input  logic                   miss_evt,
    input  logic                   coll_err_evt,
    input  logic                   babble_evt,
    output logic                   irq,
    output logic                   init_pulse,
    output logic                   start_pulse,
    output logic                   stop_pulse,
    output logic                   tx_demand,
    output logic                   tx_enable,
    output logic                   rx_enable,
    output logic [INIT_ADDR_W-1:0] init_addr,
    output logic [BUSMODE_W-1:0]   bus_mode,
    output logic [FILTER_W-1:0]    mcast_filter,
    output logic                   promisc
);

    logic [REG_SEL_W-1:0]  csr_sel;
    logic                  data_wr;
    logic                  cmd_wr;
    run_state_t            run_state;
    logic                  stopped;
    logic                  running;
    logic                  init_seen;
    logic                  inea;
    logic                  idon_set;
    logic [FLAG_COUNT-1:0] flags;
    logic [FLAG_COUNT-1:0] set_evt;
    logic [FLAG_COUNT-1:0] clr_mask;
    logic                  err_sum;
    logic                  intr_sum;
    logic [15:0]           cmd_word;
    logic [15:0]           bank_rd;
    logic [15:0]           mode_word;

    // Address port
    always_ff @(posedge clk) begin
        if (!rst_n)                   csr_sel <= '0;
        else if (host_wr && host_port) csr_sel <= host_wdata[REG_SEL_W-1:0];
    end

    assign data_wr = host_wr && !host_port;
    assign cmd_wr  = data_wr && (csr_sel == REG_SEL_W'(REGN_CMD));

    netcsr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_init   (host_wdata[C0_INIT]),
        .cmd_strt   (host_wdata[C0_STRT]),
        .cmd_stop   (host_wdata[C0_STOP]),
        .cmd_tdmd   (host_wdata[C0_TDMD]),
        .cmd_inea   (host_wdata[C0_INEA]),
        .init_done  (init_done),
        .state      (run_state),
        .init_seen  (init_seen),
        .inea       (inea),
        .tdmd       (tx_demand),
        .init_pulse (init_pulse),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .idon_set   (idon_set)
    );

    assign stopped = (run_state == RUN_STOPPED);
    assign running = (run_state == RUN_ACTIVE);

    always_comb begin
        set_evt          = '0;
        set_evt[FL_IDON] = idon_set;
        set_evt[FL_TINT] = tx_done_evt  && !stopped;
        set_evt[FL_RINT] = rx_done_evt  && !stopped;
        set_evt[FL_MERR] = mem_err_evt  && !stopped;
        set_evt[FL_MISS] = miss_evt     && !stopped;
        set_evt[FL_CERR] = coll_err_evt && !stopped;
        set_evt[FL_BABL] = babble_evt   && !stopped;
    end

    assign clr_mask = cmd_wr ? host_wdata[C0_FLAG_LO +: FLAG_COUNT] : '0;

    netcsr_flags #(.N_FLAGS(FLAG_COUNT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (cmd_wr && host_wdata[C0_STOP]),
        .set_evt (set_evt),
        .clr_mask(clr_mask),
        .flags   (flags)
    );

    netcsr_bank #(
        .REG_SEL_W  (REG_SEL_W),
        .INIT_ADDR_W(INIT_ADDR_W),
        .FILTER_W   (FILTER_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (data_wr),
        .sel      (csr_sel),
        .wdata    (host_wdata),
        .stopped  (stopped),
        .init_addr(init_addr),
        .bus_mode (bus_mode),
        .filter   (mcast_filter),
        .mode_word(mode_word),
        .rd_data  (bank_rd)
    );

    assign err_sum  = flags[FL_MERR] | flags[FL_MISS] | flags[FL_CERR] | flags[FL_BABL];
    assign intr_sum = err_sum | flags[FL_IDON] | flags[FL_TINT] | flags[FL_RINT];

    always_comb begin
        cmd_word          = '0;
        cmd_word[C0_INIT] = init_seen;
        cmd_word[C0_STRT] = running;
        cmd_word[C0_STOP] = stopped;
        cmd_word[C0_TDMD] = tx_demand;
        cmd_word[C0_TXON] = running;
        cmd_word[C0_RXON] = running;
        cmd_word[C0_INEA] = inea;
        cmd_word[C0_INTR] = intr_sum;
        cmd_word[C0_FLAG_LO +: FLAG_COUNT] = flags;
        cmd_word[C0_ERR]  = err_sum;
    end

    assign host_rdata = host_port ? 16'(csr_sel)
                      : ((csr_sel == REG_SEL_W'(REGN_CMD)) ? cmd_word : bank_rd);

    assign irq       = intr_sum & inea;
    assign tx_enable = running;
    assign rx_enable = running;
    assign promisc   = mode_word[15];

endmodule

// File: rtl/netcsr_file_chk.sv
module netcsr_file_chk #(
    parameter int REG_SEL_W   = 4,
    parameter int INIT_ADDR_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   host_wr,
    input logic                   host_port,
    input logic [15:0]            host_wdata,
    input logic [REG_SEL_W-1:0]   csr_sel,
    input logic                   stopped,
    input logic                   irq,
    input logic                   init_pulse,
    input logic                   start_pulse,
    input logic                   stop_pulse,
    input logic                   tx_demand,
    input logic                   tx_enable,
    input logic                   rx_enable,
    input logic [INIT_ADDR_W-1:0] init_addr,
    input logic [2:0]             bus_mode
);

    logic cmd_w;
    assign cmd_w = host_wr && !host_port && (csr_sel == '0);

    assert_stop_beats_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && host_wdata[2] |=> !init_pulse && stopped);

    assert_stop_quiets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !tx_enable && !rx_enable && !irq);

    assert_start_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> tx_enable && rx_enable);

    assert_tdmd_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_demand && !(cmd_w && host_wdata[3]) |=> !tx_demand);

    assert_tdmd_only_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_demand |-> tx_enable);

    assert_addr_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped && host_wr && !host_port && (csr_sel == 1 || csr_sel == 2)
        |=> $stable(init_addr));

    assert_busmode_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped && host_wr && !host_port && csr_sel == 3 |=> $stable(bus_mode));

    assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_pulse, start_pulse, stop_pulse}));

    assert_init_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

endmodule

bind netcsr_file netcsr_file_chk #(
    .REG_SEL_W  (REG_SEL_W),
    .INIT_ADDR_W(INIT_ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_port  (host_port),
    .host_wdata (host_wdata),
    .csr_sel    (csr_sel),
    .stopped    (stopped),
    .irq        (irq),
    .init_pulse (init_pulse),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .tx_demand  (tx_demand),
    .tx_enable  (tx_enable),
    .rx_enable  (rx_enable),
    .init_addr  (init_addr),
    .bus_mode   (bus_mode)
);

// File: tb/netcsr_file_test.sv
`timescale 1ns/1ps
module netcsr_file_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_port = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [6:0]  ev_bus = '0;
    logic        irq, init_pulse, start_pulse, stop_pulse, tx_demand, tx_enable, rx_enable;
    logic [23:0] init_addr;
    logic [2:0]  bus_mode;
    logic [63:0] mcast_filter;
    logic        promisc;

    always #4 clk = ~clk;

    netcsr_file uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .init_done(ev_bus[0]), .tx_done_evt(ev_bus[1]), .rx_done_evt(ev_bus[2]),
        .mem_err_evt(ev_bus[3]), .miss_evt(ev_bus[4]), .coll_err_evt(ev_bus[5]),
        .babble_evt(ev_bus[6]), .irq(irq), .init_pulse(init_pulse),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .tx_demand(tx_demand),
        .tx_enable(tx_enable), .rx_enable(rx_enable), .init_addr(init_addr),
        .bus_mode(bus_mode), .mcast_filter(mcast_filter), .promisc(promisc)
    );

    typedef struct { string tag; logic [63:0] val; } item_t;
    item_t       exp_q[$];
    logic [63:0] obs_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                item_t       e;
                logic [63:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                n_tests++;
                if (o !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%0h expected 0x%0h", e.tag, o, e.val);
                end
            end
        end
    end

    task automatic expect_val(input string tag, input logic [63:0] got, input logic [63:0] exp);
        exp_q.push_back('{tag, exp});
        obs_q.push_back(got);
    endtask

    task automatic wr_port(input logic p, input logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_port = p; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0; host_port = 1'b0;
        #1;
    endtask

    task automatic rd_reg(input int n, output logic [15:0] v);
        wr_port(1'b1, 16'(n));
        host_port = 1'b0;
        #1;
        v = host_rdata;
    endtask

    task automatic pulse_ev(input logic [6:0] m);
        @(negedge clk);
        ev_bus = m;
        @(negedge clk);
        ev_bus = '0;
        #1;
    endtask

    task automatic chk_reg(input string tag, input int n, input logic [15:0] exp);
        logic [15:0] v;
        rd_reg(n, v);
        expect_val(tag, 64'(v), 64'(exp));
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        chk_reg("R2 reset word", 0, 16'h0004);
        expect_val("R2 irq at reset", 64'(irq), 64'd0);

        // R1 address port and data port
        wr_port(1'b1, 16'd8);
        host_port = 1'b1; #1;
        expect_val("R1 address readback", 64'(host_rdata), 64'd8);
        host_port = 1'b0;
        wr_port(1'b0, 16'h1111);
        #1; expect_val("R1 data readback", 64'(host_rdata), 64'h1111);
        // R12 filter and mode
        wr_port(1'b1, 16'd9);  wr_port(1'b0, 16'h2222);
        wr_port(1'b1, 16'd10); wr_port(1'b0, 16'h3333);
        wr_port(1'b1, 16'd11); wr_port(1'b0, 16'h4444);
        expect_val("R12 filter", mcast_filter, 64'h4444_3333_2222_1111);
        wr_port(1'b1, 16'd15); wr_port(1'b0, 16'h8000);
        expect_val("R12 promisc", 64'(promisc), 64'd1);

        // R11 writable while stopped
        wr_port(1'b1, 16'd1); wr_port(1'b0, 16'h1234);
        wr_port(1'b1, 16'd2); wr_port(1'b0, 16'hFF56);
        wr_port(1'b1, 16'd3); wr_port(1'b0, 16'h0007);
        expect_val("R11 init addr", 64'(init_addr), 64'h561234);
        expect_val("R11 bus mode", 64'(bus_mode), 64'd7);
        chk_reg("R11 hi masked", 2, 16'h0056);

        // R3 probe
        wr_port(1'b1, 16'd0);
        wr_port(1'b0, 16'h0005);
        expect_val("R3 no init pulse", 64'(init_pulse), 64'd0);
        expect_val("R10 stop pulse", 64'(stop_pulse), 64'd1);
        chk_reg("R3 probe word", 0, 16'h0004);

        // R4 init then done
        wr_port(1'b0, 16'h0001);
        expect_val("R4 init pulse", 64'(init_pulse), 64'd1);
        chk_reg("R4 initing word", 0, 16'h0001);
        pulse_ev(7'b0000001);
        chk_reg("R4 idon word", 0, 16'h0181);
        expect_val("R9 irq without enable", 64'(irq), 64'd0);

        // R9 enable
        wr_port(1'b0, 16'h0040);
        expect_val("R9 irq enabled", 64'(irq), 64'd1);
        chk_reg("R8 intr word", 0, 16'h01C1);
        // R7 clear IDON
        wr_port(1'b0, 16'h0140);
        chk_reg("R7 idon cleared", 0, 16'h0041);

        // R5 start
        wr_port(1'b0, 16'h0042);
        expect_val("R5 start pulse", 64'(start_pulse), 64'd1);
        expect_val("R5 enables", 64'({tx_enable, rx_enable}), 64'd3);
        chk_reg("R5 active word", 0, 16'h0073);

        // R11 locked while active
        wr_port(1'b1, 16'd1); wr_port(1'b0, 16'hFFFF);
        chk_reg("R11 locked while active", 1, 16'h1234);

        // R6 transmit demand
        wr_port(1'b1, 16'd0);
        wr_port(1'b0, 16'h0048);
        expect_val("R6 demand raised", 64'(tx_demand), 64'd1);
        @(negedge clk); #1;
        expect_val("R6 demand self clears", 64'(tx_demand), 64'd0);

        // R7/R8 flags
        pulse_ev(7'b1000000);
        chk_reg("R8 babble err word", 0, 16'hC0F3);
        expect_val("R9 irq on error", 64'(irq), 64'd1);
        wr_port(1'b0, 16'h0040);
        chk_reg("R7 zero write no effect", 0, 16'hC0F3);
        wr_port(1'b0, 16'h4040);
        chk_reg("R7 babble cleared", 0, 16'h0073);
        pulse_ev(7'b0001010);
        chk_reg("R8 tint merr word", 0, 16'h8AF3);
        // clear TINT and MERR while a new transmit event arrives
        @(negedge clk);
        host_wr = 1'b1; host_port = 1'b0; host_wdata = 16'h0A40; ev_bus = 7'b0000010;
        @(negedge clk);
        host_wr = 1'b0; ev_bus = '0; #1;
        chk_reg("R7 event beats clear", 0, 16'h02F3);
        wr_port(1'b0, 16'h0240);

        // R10 stop
        wr_port(1'b0, 16'h0004);
        expect_val("R10 stop pulse", 64'(stop_pulse), 64'd1);
        expect_val("R10 quiet", 64'({irq, tx_enable, rx_enable}), 64'd0);
        chk_reg("R10 stopped word", 0, 16'h0004);

        // R13 events ignored when stopped
        pulse_ev(7'b1111110);
        chk_reg("R13 no flags when stopped", 0, 16'h0004);

        // R6 demand ignored when stopped
        wr_port(1'b0, 16'h0008);
        expect_val("R6 demand ignored", 64'(tx_demand), 64'd0);
        chk_reg("R6 stopped word", 0, 16'h0004);

        // R4 init with start
        wr_port(1'b0, 16'h0003);
        expect_val("R4 init pulse combined", 64'(init_pulse), 64'd1);
        expect_val("R4 no early start", 64'(start_pulse), 64'd0);
        chk_reg("R4 waiting word", 0, 16'h0001);
        pulse_ev(7'b0000001);
        expect_val("R4 start after done", 64'(start_pulse), 64'd1);
        chk_reg("R4 running word", 0, 16'h01B3);

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule